// File: doc/BRIEF.md
# Coded Frame Formatter and Pacer

This block sits on the read side of a dual-clock byte FIFO and turns the payload stream into fixed-length transmit frames. Each frame opens with a 32-bit pseudo-noise sync word, which lets the far end find the frame and byte boundaries. The payload burst follows, then a balancing header byte, then the check bytes that an external block encoder supplies through a valid/ready port. Payload is pulled at one byte per clock. Between two bursts the reads stop for a fixed window, and the inserted bytes fill that window, so the output byte rate stays constant.

Framing begins only once the FIFO reports half full. From then on, frames follow each other with no gap. A stall occurs when the FIFO runs dry inside a burst or when the encoder is late with a check byte. During a stall the frame position is frozen and no byte is emitted, and the frame then resumes where it stopped, so no partial frame is ever sent. A FIFO starvation also sets a sticky underrun flag. All output bytes are registered, and each appears one clock after the cycle in which it was selected.

Top module: `txfp_pacer`

## Requirements
- R1: While reset is held, and after it is released, out_valid, out_sof, underrun, fifo_rd_en and par_ready are all low until framing starts.
- R2: No frame starts and no FIFO read occurs until fifo_half has been seen high. The first frame position is taken on the clock after that, and later frames follow back to back.
- R3: A frame is 260 positions in this order: 4 sync bytes, 239 payload bytes, 1 header byte, 16 check bytes. A position that is not stalled yields one output byte with out_valid high on the following clock, and out_sof is high only with the first sync byte.
- R4: The sync bytes come from a 5-bit register r seeded to 5'b11111. Each step emits r[4] as the next chip, then shifts r to {r[3:0], r[4]^r[1]} (polynomial x^5+x^3+1). The 31 chips are followed by one 0 bit, and the 32 bits are sent MSB first, with chip 0 in bit 7 of the first sync byte.
- R5: fifo_rd_en is high exactly in payload positions where fifo_empty is low. The head byte of the FIFO (fifo_rd_data) in that cycle is the next output byte. Each frame makes exactly 239 reads.
- R6: The header byte is 8'h00.
- R7: par_ready is high in every cycle that sits at a check-byte position. When par_valid is also high, par_data is the next output byte.
- R8: When no stall occurs, exactly 21 cycles with fifo_rd_en low separate the last read of one burst from the first read of the next.
- R9: If fifo_empty is high at a payload position, no read happens, out_valid is low on the next clock, and the position is held. Underrun is set and stays high until reset.
- R10: If par_valid is low at a check-byte position, the position is held and out_valid is low on the next clock, but underrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_rd_data | input | 8 | Head byte of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_half | input | 1 | FIFO at least half full |
| fifo_rd_en | output | 1 | Pops the head byte at this edge |
| par_data | input | 8 | Check byte from the encoder |
| par_valid | input | 1 | par_data is present |
| par_ready | output | 1 | Pacer is at a check-byte position |
| out_data | output | 8 | Framed output byte |
| out_valid | output | 1 | out_data carries a frame byte |
| out_sof | output | 1 | First byte of a frame |
| underrun | output | 1 | Sticky: FIFO ran dry inside a burst |

## Verification
The assertions assume a show-ahead FIFO: fifo_rd_data is the head byte whenever fifo_empty is low, and a pop takes effect at the edge where fifo_rd_en is high. They also assume that fifo_half never claims data the FIFO does not hold. The bench keeps within these assumptions by building the FIFO itself as a queue that it pops on the reads it predicts, and by deriving empty and half-full from the queue's fill. The stimulus then takes the pacer through a delayed start, undisturbed back-to-back frames, a window of late check bytes and a long starvation.

// File: rtl/txfp_pkg.sv
package txfp_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_BODY = 2'd1,
      SEG_HEAD = 2'd2,
      SEG_CHECK = 2'd3
   } seg_e;

endpackage

// File: rtl/txfp_seq.sv
module txfp_seq
   import txfp_pkg::*;
#(
   parameter int SYNC_BYTES = 4,
   parameter int BODY_LEN = 239,
   parameter int CHECK_LEN = 16,
   localparam int FRAME_LEN = SYNC_BYTES + BODY_LEN + 1 + CHECK_LEN,
   localparam int POS_W = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ok,
   input  logic             stall,
   output logic             running,
   output logic [POS_W-1:0] pos,
   output seg_e             seg,
   output logic             frame_end
);

   localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);
   localparam logic [POS_W-1:0] BODY_START = POS_W'(SYNC_BYTES);
   localparam logic [POS_W-1:0] HEAD_POS = POS_W'(SYNC_BYTES + BODY_LEN);

   always_comb begin
      if (pos < BODY_START)     seg = SEG_SYNC;
      else if (pos < HEAD_POS)  seg = SEG_BODY;
      else if (pos == HEAD_POS) seg = SEG_HEAD;
      else                      seg = SEG_CHECK;
   end

   assign frame_end = running && !stall && (pos == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         pos     <= '0;
      end else if (!running) begin
         if (start_ok) running <= 1'b1;
         pos <= '0;
      end else if (!stall) begin
         pos <= (pos == LAST) ? '0 : pos + 1'b1;
      end
   end

   // R3: position never leaves the frame
   a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (pos <= LAST));

   // R9 / R10: a stalled position is held
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (running && stall) |=> $stable(pos));

endmodule

// File: rtl/txfp_sync.sv
module txfp_sync
   import txfp_pkg::*;
#(
   parameter int SYNC_BYTES = 4,
   parameter int LFSR_W = 5,
   parameter int LFSR_TAP = 1,
   parameter logic [LFSR_W-1:0] LFSR_SEED = '1,
   localparam int WORD_W = SYNC_BYTES * BYTE_W,
   localparam int CHIPS = (1 << LFSR_W) - 1,
   localparam int SEL_W = $clog2(SYNC_BYTES)
) (
   input  logic [SEL_W-1:0]  sel,
   output logic [BYTE_W-1:0] sync_byte
);

   function automatic logic [WORD_W-1:0] build_word();
      logic [LFSR_W-1:0] r;
      logic [WORD_W-1:0] w;
      r = LFSR_SEED;
      w = '0;
      for (int i = 0; i < CHIPS; i++) begin
         w[WORD_W-1-i] = r[LFSR_W-1];
         r = {r[LFSR_W-2:0], r[LFSR_W-1] ^ r[LFSR_TAP]};
      end
      return w;
   endfunction

   localparam logic [WORD_W-1:0] WORD = build_word();

   logic [BYTE_W-1:0] tbl [SYNC_BYTES];

   generate
      if (CHIPS != WORD_W - 1) begin : g_bad_len
         $error("txfp_sync: PN length must be one short of the sync word");
      end
      if (SYNC_BYTES < 2 || (1 << SEL_W) != SYNC_BYTES) begin : g_bad_cnt
         $error("txfp_sync: sync byte count must be a power of two >= 2");
      end
      for (genvar i = 0; i < SYNC_BYTES; i++) begin : g_byte
         assign tbl[i] = WORD[WORD_W-1-BYTE_W*i -: BYTE_W];
      end
   endgenerate

   assign sync_byte = tbl[sel];

endmodule

// File: rtl/txfp_outreg.sv
module txfp_outreg
   import txfp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              emit,
   input  logic              first,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_sof
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
      end else begin
         out_valid <= emit;
         out_sof   <= emit && first;
         if (emit) out_data <= byte_in;
      end
   end

   // R3: a frame start is always a valid byte
   a_r3_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   // R3: two frame starts are never adjacent
   a_r3_sof_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |=> !out_sof);

endmodule

// File: rtl/txfp_pacer.sv
module txfp_pacer
   import txfp_pkg::*;
#(
   parameter int SYNC_BYTES = 4,
   parameter int BODY_LEN = 239,
   parameter int CHECK_LEN = 16,
   parameter logic [7:0] HEAD_VAL = 8'h00,
   parameter int LFSR_W = 5,
   parameter int LFSR_TAP = 1,
   parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] fifo_rd_data,
   input  logic       fifo_empty,
   input  logic       fifo_half,
   output logic       fifo_rd_en,
   input  logic [7:0] par_data,
   input  logic       par_valid,
   output logic       par_ready,
   output logic [7:0] out_data,
   output logic       out_valid,
   output logic       out_sof,
   output logic       underrun
);

   localparam int FRAME_LEN = SYNC_BYTES + BODY_LEN + 1 + CHECK_LEN;
   localparam int POS_W = $clog2(FRAME_LEN);
   localparam int SEL_W = $clog2(SYNC_BYTES);
   localparam int CNT_W = $clog2(BODY_LEN + 1);

   generate
      if (((BODY_LEN + 1 + CHECK_LEN) % 8) != 0) begin : g_bad_coded
         $error("txfp_pacer: coded part of the frame must be a multiple of 8");
      end
      if (BODY_LEN < 1 || CHECK_LEN < 1) begin : g_bad_field
         $error("txfp_pacer: body and check fields must be non-empty");
      end
   endgenerate

   logic             running;
   logic [POS_W-1:0] pos;
   seg_e             seg;
   logic             frame_end;
   logic             stall;
   logic             at_body;
   logic             at_check;
   logic             starve;
   logic             emit;
   logic [7:0]       sync_byte;
   logic [7:0]       sel_byte;

   assign at_body  = running && (seg == SEG_BODY);
   assign at_check = running && (seg == SEG_CHECK);
   assign starve   = at_body && fifo_empty;
   assign stall    = starve || (at_check && !par_valid);
   assign emit     = running && !stall;

   assign fifo_rd_en = at_body && !fifo_empty;
   assign par_ready  = at_check;

   txfp_seq #(
      .SYNC_BYTES(SYNC_BYTES),
      .BODY_LEN  (BODY_LEN),
      .CHECK_LEN (CHECK_LEN)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_ok (fifo_half),
      .stall    (stall),
      .running  (running),
      .pos      (pos),
      .seg      (seg),
      .frame_end(frame_end)
   );

   txfp_sync #(
      .SYNC_BYTES(SYNC_BYTES),
      .LFSR_W    (LFSR_W),
      .LFSR_TAP  (LFSR_TAP),
      .LFSR_SEED (LFSR_SEED)
   ) u_sync (
      .sel      (pos[SEL_W-1:0]),
      .sync_byte(sync_byte)
   );

   always_comb begin
      unique case (seg)
         SEG_SYNC:  sel_byte = sync_byte;
         SEG_BODY:  sel_byte = fifo_rd_data;
         SEG_HEAD:  sel_byte = HEAD_VAL;
         default:   sel_byte = par_data;
      endcase
   end

   txfp_outreg u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .emit     (emit),
      .first    (pos == '0),
      .byte_in  (sel_byte),
      .out_data (out_data),
      .out_valid(out_valid),
      .out_sof  (out_sof)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) underrun <= 1'b0;
      else if (starve) underrun <= 1'b1;
   end

   // Reads made in the current frame, kept for the burst-length check
   logic [CNT_W-1:0] rd_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)          rd_cnt <= '0;
      else if (frame_end)  rd_cnt <= '0;
      else if (fifo_rd_en) rd_cnt <= rd_cnt + 1'b1;
   end

   // R5: every frame pulls exactly one burst of payload
   a_r5_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> (rd_cnt == CNT_W'(BODY_LEN)));

   // R9: the underrun flag is sticky
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);

   // R7: payload reads and check-byte acceptance never overlap
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fifo_rd_en, par_ready}));

   // R2: nothing is drained before framing has started
   a_r2_no_early_read: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !(fifo_rd_en || par_ready || emit));

endmodule

// File: tb/txfp_pacer_tb.sv
`timescale 1ns/1ps
module txfp_pacer_tb;

   localparam int HALF = 128;
   localparam int RUN_CYCLES = 2400;
   localparam int FRAME = 260;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] fifo_rd_data = '0;
   logic       fifo_empty = 1'b1;
   logic       fifo_half = 1'b0;
   logic       fifo_rd_en;
   logic [7:0] par_data = '0;
   logic       par_valid = 1'b0;
   logic       par_ready;
   logic [7:0] out_data;
   logic       out_valid;
   logic       out_sof;
   logic       underrun;

   always #2.5 clk = ~clk;

   txfp_pacer u_dut (
      .clk(clk), .rst_n(rst_n),
      .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty), .fifo_half(fifo_half),
      .fifo_rd_en(fifo_rd_en),
      .par_data(par_data), .par_valid(par_valid), .par_ready(par_ready),
      .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
      .underrun(underrun)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Sync bytes from the stated chip rule (R4)
   logic [7:0] sync_ref [4];
   initial begin
      logic [4:0]  r;
      logic [31:0] w;
      r = 5'b11111;
      w = '0;
      for (int i = 0; i < 31; i++) begin
         w[31-i] = r[4];
         r = {r[3:0], r[4] ^ r[1]};
      end
      for (int k = 0; k < 4; k++) sync_ref[k] = w[31-8*k -: 8];
   end

   // Reference state
   logic [7:0] q[$];
   int   mrun = 0, mpos = 0;
   bit   m_under = 0;
   bit   pop_pending = 0, par_take = 0;
   bit   exp_valid = 0, exp_sof = 0;
   logic [7:0] exp_data = '0;
   string dtag = "R3", vtag = "R3";
   int   par_cnt = 0;
   logic [7:0] body_seq = 8'h00;
   bit   feed = 0, par_gap = 0;
   int   n_sof = 0, n_reads = 0;
   bit   seen_read = 0, gap_done = 0;
   int   gap = 0;

   initial begin
      #(5.0 * 3000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 out_sof", int'(out_sof), 0);
      chk("R1 underrun", int'(underrun), 0);
      chk("R1 fifo_rd_en", int'(fifo_rd_en), 0);
      chk("R1 par_ready", int'(par_ready), 0);
      rst_n = 1'b1;

      for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
         @(negedge clk);
         if (pop_pending) void'(q.pop_front());
         if (par_take) par_cnt++;

         // compare the registered outputs of the edge just passed
         chk({vtag, " out_valid"}, int'(out_valid), int'(exp_valid));
         chk("R3 out_sof", int'(out_sof), int'(exp_sof));
         if (exp_valid) chk({dtag, " out_data"}, int'(out_data), int'(exp_data));
         chk("R9 underrun", int'(underrun), int'(m_under));
         if (out_sof) n_sof++;

         // stimulus phases
         if (cyc == 0) begin
            for (int k = 0; k < 100; k++) begin q.push_back(body_seq); body_seq++; end
         end
         if (cyc == 20) begin
            // R2: below half full nothing has started
            chk("R2 idle out_valid", int'(out_valid), 0);
            chk("R2 idle reads", n_reads, 0);
            for (int k = 0; k < 200; k++) begin q.push_back(body_seq); body_seq++; end
            feed = 1;
         end
         par_gap = (cyc >= 800 && cyc < 1100);
         if (cyc == 1200) feed = 0;
         if (cyc == 1800) feed = 1;
         if (feed) begin q.push_back(body_seq); body_seq = body_seq + 8'd3; end

         fifo_empty   = (q.size() == 0);
         fifo_half    = (q.size() >= HALF);
         fifo_rd_data = (q.size() > 0) ? q[0] : 8'hEE;
         par_data     = 8'hC0 ^ 8'(par_cnt);
         par_valid    = !(par_gap && (cyc % 5 == 0));

         #1;
         begin
            bit e_rd, e_pr, e_emit;
            logic [7:0] b;
            e_rd = 0; e_pr = 0; e_emit = 0; b = '0;
            dtag = "R3"; vtag = "R3";
            if (mrun != 0) begin
               if (mpos < 4) begin
                  b = sync_ref[mpos]; e_emit = 1; dtag = "R4";
               end else if (mpos < 243) begin
                  dtag = "R5"; vtag = "R9";
                  if (q.size() > 0) begin e_rd = 1; e_emit = 1; b = q[0]; end
                  else m_under = 1;
               end else if (mpos == 243) begin
                  b = 8'h00; e_emit = 1; dtag = "R6";
               end else begin
                  e_pr = 1; dtag = "R7"; vtag = "R10";
                  if (par_valid) begin e_emit = 1; b = par_data; end
               end
            end
            chk("R5 fifo_rd_en", int'(fifo_rd_en), int'(e_rd));
            chk("R7 par_ready", int'(par_ready), int'(e_pr));

            // R8: quiet window between the first two bursts
            if (fifo_rd_en) begin
               n_reads++;
               if (seen_read && gap > 0 && !gap_done) begin
                  chk("R8 read gap", gap, 21);
                  gap_done = 1;
               end
               gap = 0;
               seen_read = 1;
            end else if (seen_read) gap++;

            exp_valid = e_emit;
            exp_sof   = e_emit && (mpos == 0);
            if (e_emit) exp_data = b;
            pop_pending = e_rd;
            par_take    = e_pr && par_valid;

            if (mrun == 0) begin
               if (q.size() >= HALF) begin mrun = 1; mpos = 0; end
            end else if (e_emit) begin
               mpos = (mpos == FRAME - 1) ? 0 : mpos + 1;
            end
         end
      end

      @(negedge clk);
      chk("R9 underrun seen", int'(underrun), 1);
      chk("R3 frames started", int'(n_sof >= 7), 1);
      chk("R8 gap measured", int'(gap_done), 1);
      done = 1;
      finish_run();
   end

endmodule